// File: doc/BRIEF.md
# Pulse Arrival Time and Charge Extractor

The block takes one window of 8-bit flash-digitizer codes that belong to a single candidate hit on a wire and reduces it to a hit flag, a sub-bin arrival time and an integrated charge. The digitizer's response is nonlinear, so each code is first passed through a programmable correction table. A programmable pedestal is then subtracted, with results below zero held at zero. The corrected samples are stored in a small window buffer. While they arrive, the block tracks the steepest positive step between neighbouring samples and checks whether two neighbouring samples both lie above a threshold.

After the last sample, a controller works through five states. FILL collects samples and leaves for CENT on the sample flagged last. CENT forms a weighted centre of gravity over four sample differences placed around the steepest step. It goes to EMIT when the candidate is rejected, to CHG when the weight sum is zero, and to DIV otherwise. DIV runs a six-step restoring division and goes to CHG when the quotient is ready. CHG adds up to fifteen samples, one per cycle, and goes to EMIT. EMIT publishes the result and returns to FILL. Four 4-bit weights let the user bias the centroid toward the rising edge and tune out small timing offsets.

Top module: `pulse_tq_extract`

## Requirements
- R1: While reset is held and after its release, res_valid, res_hit, res_trunc, res_time and res_charge are all zero.
- R2: Each stored sample is the correction table entry for its code (the table is written through cfg_lut_we/addr/data) minus cfg_ped, floored at zero. Reprogramming the table changes the results accordingly.
- R3: The steepest rise k is the index i (1 ≤ i < n, where n is the number of stored samples) with the largest positive difference s[i]−s[i−1]. When several differences are equal, the earliest one wins.
- R4: A hit is accepted only if the largest rise exceeds cfg_min_rise and two neighbouring stored samples are both above cfg_thr. A rejected window reports res_hit=0 and zero time, charge and truncation.
- R5: Weight j (j=0..3) sits at cfg_wgt[4j+3:4j] and applies to difference bin k−1+j. A difference bin i is max(s[i]−s[i−1],0), and counts only when 1 ≤ i < n. With B=Σw·d and A=Σw·d·j, res_time = (k−1)·16 + floor(16·A/B).
- R6: If B is zero, res_time = k·16, which is the integer bin with a zero fraction.
- R7: res_charge is the sum of the 15 stored samples starting at index k−1.
- R8: If index k−1+15 runs past n, the charge is the sum over the samples that remain and res_trunc is 1.
- R9: Each window produces exactly one res_valid pulse, one cycle long. The result outputs change only together with that pulse.
- R10: Only the first 32 samples of a window are stored. Later samples, up to the one flagged last, have no effect.
- R11: Samples presented while a window is still being processed (between the last sample and the result pulse) are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lut_we | input | 1 | Write strobe for the correction table |
| cfg_lut_addr | input | 8 | Table entry (digitizer code) to write |
| cfg_lut_data | input | 10 | Linear amplitude for that code |
| cfg_ped | input | 10 | Pedestal subtracted after correction |
| cfg_thr | input | 10 | Threshold for the two-sample check |
| cfg_min_rise | input | 10 | Largest rise must exceed this |
| cfg_wgt | input | 16 | Four 4-bit centroid weights |
| smp_valid | input | 1 | Sample strobe |
| smp_code | input | 8 | Raw digitizer code |
| smp_last | input | 1 | Marks the final sample of a window |
| res_valid | output | 1 | One-cycle result strobe |
| res_hit | output | 1 | Candidate accepted |
| res_time | output | 10 | Arrival time in 1/16 bin units |
| res_charge | output | 14 | Summed amplitude |
| res_trunc | output | 1 | Charge window was cut short |

## Verification
The random windows place pulses anywhere in the window, including at the very start and the very end, and draw random weights, so the truncated charge sum and the centroid taps that fall outside the window both get exercised. A design that handled the edge taps wrongly would shift the time by a fraction of a bin. A design that summed past the end would report charge from stale buffer contents. Directed windows cover the following cases:
- Equal rises. Picking the later rise would move the time by a whole bin.
- All-zero weights. A design that divides anyway would return garbage instead of k·16.
- A single-sample spike that must be rejected.
- A pulse placed past the 32nd sample, which a design without the overflow guard would wrap into the buffer.
- Junk samples sent while a window is busy. A design that accepted them would corrupt the next window's time and charge.

// File: rtl/pte_pkg.sv
package pte_pkg;
    typedef enum logic [2:0] {
        ST_FILL = 3'd0,
        ST_CENT = 3'd1,
        ST_DIV  = 3'd2,
        ST_CHG  = 3'd3,
        ST_EMIT = 3'd4
    } pte_state_e;

    localparam int unsigned NUM_TAPS = 4;
    localparam int unsigned CODE_W   = 8;
endpackage

// File: rtl/pte_lin_lut.sv
module pte_lin_lut #(
    parameter int unsigned CODE_W = 8,
    parameter int unsigned LW     = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [CODE_W-1:0] waddr,
    input  logic [LW-1:0]     wdata,
    input  logic [CODE_W-1:0] raddr,
    output logic [LW-1:0]     rdata
);
    localparam int unsigned DEPTH = 1 << CODE_W;

    logic [LW-1:0] table_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            table_q[waddr] <= wdata;
        end
    end

    assign rdata = table_q[raddr];
endmodule

// File: rtl/pte_edge_scan.sv
module pte_edge_scan #(
    parameter int unsigned LW = 10,
    parameter int unsigned IW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic          first,
    input  logic [LW-1:0] s_in,
    input  logic [LW-1:0] thr,
    input  logic [IW-1:0] idx,
    output logic [LW-1:0] max_rise,
    output logic [IW-1:0] max_idx,
    output logic          run_ok
);
    logic [LW-1:0] prev_q;
    logic          above_q;
    logic [LW-1:0] rise;
    logic          above;

    always_comb begin
        rise  = (!first && (s_in > prev_q)) ? (s_in - prev_q) : '0;
        above = (s_in > thr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q   <= '0;
            above_q  <= 1'b0;
            max_rise <= '0;
            max_idx  <= '0;
            run_ok   <= 1'b0;
        end else if (clr) begin
            prev_q   <= '0;
            above_q  <= 1'b0;
            max_rise <= '0;
            max_idx  <= '0;
            run_ok   <= 1'b0;
        end else if (en) begin
            prev_q  <= s_in;
            above_q <= above;
            if (above && above_q) begin
                run_ok <= 1'b1;
            end
            // strict compare keeps the earliest of equal rises
            if (rise > max_rise) begin
                max_rise <= rise;
                max_idx  <= idx;
            end
        end
    end
endmodule

// File: rtl/pte_seq_div.sv
module pte_seq_div #(
    parameter int unsigned RW = 23,
    parameter int unsigned QW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [RW-1:0] num,
    input  logic [RW-1:0] den,
    output logic          done,
    output logic [QW-1:0] quot
);
    localparam int unsigned SW = $clog2(QW);

    logic [RW-1:0] rem_q;
    logic [RW-1:0] dsh_q;
    logic [SW-1:0] step_q;
    logic          busy_q;
    logic          ge;

    assign ge = (rem_q >= dsh_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            dsh_q  <= '0;
            step_q <= '0;
            busy_q <= 1'b0;
            done   <= 1'b0;
            quot   <= '0;
        end else if (start) begin
            rem_q  <= num;
            dsh_q  <= den << (QW - 1);
            step_q <= SW'(QW - 1);
            busy_q <= 1'b1;
            done   <= 1'b0;
            quot   <= '0;
        end else if (busy_q) begin
            if (ge) begin
                rem_q <= rem_q - dsh_q;
            end
            quot  <= {quot[QW-2:0], ge};
            dsh_q <= dsh_q >> 1;
            if (step_q == '0) begin
                busy_q <= 1'b0;
                done   <= 1'b1;
            end else begin
                step_q <= step_q - SW'(1);
            end
        end else begin
            done <= 1'b0;
        end
    end
endmodule

// File: rtl/pulse_tq_extract.sv
module pulse_tq_extract
    import pte_pkg::*;
#(
    parameter int unsigned NS      = 32,
    parameter int unsigned LW      = 10,
    parameter int unsigned WW      = 4,
    parameter int unsigned CHG_LEN = 15,
    localparam int unsigned IW     = $clog2(NS),
    localparam int unsigned TW     = IW + 5,
    localparam int unsigned CW     = LW + $clog2(CHG_LEN + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_lut_we,
    input  logic [7:0]               cfg_lut_addr,
    input  logic [LW-1:0]            cfg_lut_data,
    input  logic [LW-1:0]            cfg_ped,
    input  logic [LW-1:0]            cfg_thr,
    input  logic [LW-1:0]            cfg_min_rise,
    input  logic [NUM_TAPS*WW-1:0]   cfg_wgt,
    input  logic                     smp_valid,
    input  logic [7:0]               smp_code,
    input  logic                     smp_last,
    output logic                     res_valid,
    output logic                     res_hit,
    output logic [TW-1:0]            res_time,
    output logic [CW-1:0]            res_charge,
    output logic                     res_trunc
);
    localparam int unsigned NCW = IW + 1;
    localparam int unsigned QW  = 6;
    localparam int unsigned PW  = LW + WW;
    localparam int unsigned BW  = PW + 2;
    localparam int unsigned AW  = PW + 4;
    localparam int unsigned RW  = AW + 5;
    localparam int unsigned CCW = $clog2(CHG_LEN);

    pte_state_e st_q, st_d;

    logic [LW-1:0]  smp_buf [NS];
    logic [NCW-1:0] cnt_q;
    logic [LW-1:0]  lin;
    logic [LW-1:0]  s_lin;
    logic           take, store;

    logic [LW-1:0]  max_rise;
    logic [IW-1:0]  max_idx;
    logic           run_ok;
    logic           hit_ok;

    logic [PW-1:0]  tap_wd [NUM_TAPS];
    logic [BW-1:0]  b_sum;
    logic [AW-1:0]  a_sum;

    logic           div_start, div_done;
    logic [QW-1:0]  div_quot;

    logic           hit_q, trunc_q;
    logic [TW-1:0]  time_q;
    logic [CW-1:0]  chg_q;
    logic [NCW-1:0] ci_q;
    logic [CCW-1:0] cc_q;

    // ---------------- sample path ----------------
    pte_lin_lut #(.CODE_W(CODE_W), .LW(LW)) i_lut (
        .clk   (clk),
        .we    (cfg_lut_we),
        .waddr (cfg_lut_addr),
        .wdata (cfg_lut_data),
        .raddr (smp_code),
        .rdata (lin)
    );

    assign s_lin = (lin > cfg_ped) ? (lin - cfg_ped) : '0;
    assign take  = (st_q == ST_FILL) && smp_valid;
    assign store = take && (cnt_q < NCW'(NS));

    always_ff @(posedge clk) begin
        if (store) begin
            smp_buf[cnt_q[IW-1:0]] <= s_lin;
        end
    end

    pte_edge_scan #(.LW(LW), .IW(IW)) i_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (st_q == ST_EMIT),
        .en       (store),
        .first    (cnt_q == '0),
        .s_in     (s_lin),
        .thr      (cfg_thr),
        .idx      (cnt_q[IW-1:0]),
        .max_rise (max_rise),
        .max_idx  (max_idx),
        .run_ok   (run_ok)
    );

    assign hit_ok = (max_rise > cfg_min_rise) && run_ok;

    // ---------------- centroid taps ----------------
    for (genvar j = 0; j < NUM_TAPS; j++) begin : g_tap
        logic [IW+1:0] pos;
        logic          in_rng;
        logic [LW-1:0] cur, prv, dif;

        assign pos    = (IW+2)'(max_idx) + (IW+2)'(j) - (IW+2)'(1);
        assign in_rng = (pos >= (IW+2)'(1)) && (pos < (IW+2)'(cnt_q));
        assign cur    = smp_buf[pos[IW-1:0]];
        assign prv    = smp_buf[pos[IW-1:0] - IW'(1)];
        assign dif    = (in_rng && (cur > prv)) ? (cur - prv) : '0;
        assign tap_wd[j] = PW'(cfg_wgt[j*WW +: WW]) * PW'(dif);
    end

    always_comb begin
        b_sum = '0;
        a_sum = '0;
        for (int j = 0; j < NUM_TAPS; j++) begin
            b_sum = b_sum + BW'(tap_wd[j]);
            a_sum = a_sum + AW'(tap_wd[j]) * AW'(j);
        end
    end

    assign div_start = (st_q == ST_CENT) && hit_ok && (b_sum != '0);

    pte_seq_div #(.RW(RW), .QW(QW)) i_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (RW'({a_sum, 4'b0000})),
        .den   (RW'(b_sum)),
        .done  (div_done),
        .quot  (div_quot)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_FILL;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_FILL: if (take && smp_last) st_d = ST_CENT;
            ST_CENT: begin
                if (!hit_ok)           st_d = ST_EMIT;
                else if (b_sum == '0)  st_d = ST_CHG;
                else                   st_d = ST_DIV;
            end
            ST_DIV:  if (div_done) st_d = ST_CHG;
            ST_CHG: begin
                if (ci_q >= cnt_q)                   st_d = ST_EMIT;
                else if (cc_q == CCW'(CHG_LEN - 1))  st_d = ST_EMIT;
            end
            ST_EMIT: st_d = ST_FILL;
            default: st_d = ST_FILL;
        endcase
    end

    // ---------------- work registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            hit_q   <= 1'b0;
            trunc_q <= 1'b0;
            time_q  <= '0;
            chg_q   <= '0;
            ci_q    <= '0;
            cc_q    <= '0;
        end else begin
            unique case (st_q)
                ST_FILL: begin
                    if (store) cnt_q <= cnt_q + NCW'(1);
                end
                ST_CENT: begin
                    hit_q   <= hit_ok;
                    trunc_q <= 1'b0;
                    chg_q   <= '0;
                    ci_q    <= NCW'(max_idx) - NCW'(1);
                    cc_q    <= '0;
                    time_q  <= (hit_ok && (b_sum == '0)) ? TW'({max_idx, 4'b0000}) : '0;
                end
                ST_DIV: begin
                    if (div_done) begin
                        time_q <= TW'({max_idx - IW'(1), 4'b0000}) + TW'(div_quot);
                    end
                end
                ST_CHG: begin
                    if (ci_q >= cnt_q) begin
                        trunc_q <= 1'b1;
                    end else begin
                        chg_q <= chg_q + CW'(smp_buf[ci_q[IW-1:0]]);
                        ci_q  <= ci_q + NCW'(1);
                        cc_q  <= cc_q + CCW'(1);
                    end
                end
                ST_EMIT: cnt_q <= '0;
                default: cnt_q <= '0;
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_hit    <= 1'b0;
            res_time   <= '0;
            res_charge <= '0;
            res_trunc  <= 1'b0;
        end else begin
            res_valid <= (st_q == ST_EMIT);
            if (st_q == ST_EMIT) begin
                res_hit    <= hit_q;
                res_time   <= time_q;
                res_charge <= chg_q;
                res_trunc  <= trunc_q;
            end
        end
    end
endmodule

// File: rtl/pulse_tq_extract_chk.sv
module pulse_tq_extract_chk #(
    parameter int unsigned LW      = 10,
    parameter int unsigned TW      = 10,
    parameter int unsigned CW      = 14,
    parameter int unsigned CHG_LEN = 15
) (
    input logic          clk,
    input logic          rst_n,
    input logic          res_valid,
    input logic          res_hit,
    input logic [TW-1:0] res_time,
    input logic [CW-1:0] res_charge,
    input logic          res_trunc
);
    localparam logic [CW-1:0] CHG_MAX = CW'(CHG_LEN * ((1 << LW) - 1));

    // R9: result strobe is a single cycle
    a_r9_one_cycle_valid: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R9: time only moves with the strobe
    a_r9_time_held: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(res_time) |-> res_valid);

    // R9: charge only moves with the strobe
    a_r9_charge_held: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(res_charge) |-> res_valid);

    // R4: a rejected window carries no time, charge or truncation
    a_r4_reject_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_time == '0 && res_charge == '0 && !res_trunc));

    // R8: truncation is only reported for accepted hits
    a_r8_trunc_only_hit: assert property (@(posedge clk) disable iff (!rst_n)
        res_trunc |-> res_hit);

    // R7: a window of CHG_LEN samples cannot exceed its full-scale sum
    a_r7_charge_bound: assert property (@(posedge clk) disable iff (!rst_n)
        res_charge <= CHG_MAX);
endmodule

bind pulse_tq_extract pulse_tq_extract_chk #(
    .LW(LW), .TW(TW), .CW(CW), .CHG_LEN(CHG_LEN)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .res_valid  (res_valid),
    .res_hit    (res_hit),
    .res_time   (res_time),
    .res_charge (res_charge),
    .res_trunc  (res_trunc)
);

// File: tb/test_pulse_tq_extract.sv
`timescale 1ns/1ps
module test_pulse_tq_extract;
    localparam int NS = 32;
    localparam int LW = 10;
    localparam int TW = 10;
    localparam int CW = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_lut_we = 1'b0;
    logic [7:0]    cfg_lut_addr = '0;
    logic [LW-1:0] cfg_lut_data = '0;
    logic [LW-1:0] cfg_ped = '0;
    logic [LW-1:0] cfg_thr = '0;
    logic [LW-1:0] cfg_min_rise = '0;
    logic [15:0]   cfg_wgt = '0;
    logic          smp_valid = 1'b0;
    logic [7:0]    smp_code = '0;
    logic          smp_last = 1'b0;
    logic          res_valid, res_hit, res_trunc;
    logic [TW-1:0] res_time;
    logic [CW-1:0] res_charge;

    pulse_tq_extract i_pulse_tq_extract (.*);

    always #10 clk = ~clk;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 0;
    bit  lut_ident = 0;
    int  win_code [64];
    int  ped, thr, min_rise;
    int  wgt [4];
    int  e_hit, e_time, e_chg, e_trunc, e_zb;

    function automatic int lin_of(int c);
        return lut_ident ? c : c + (c * c) / 256;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic void model(int len);
        int s [64];
        int n, maxd, k, run, a, b, d, p;
        n = (len < NS) ? len : NS;
        for (int i = 0; i < n; i++) begin
            s[i] = lin_of(win_code[i]) - ped;
            if (s[i] < 0) s[i] = 0;
        end
        maxd = 0; k = 0; run = 0;
        for (int i = 1; i < n; i++) begin
            d = s[i] - s[i-1];
            if (d > maxd) begin maxd = d; k = i; end
            if (s[i] > thr && s[i-1] > thr) run = 1;
        end
        e_hit = (maxd > min_rise && run == 1) ? 1 : 0;
        e_time = 0; e_chg = 0; e_trunc = 0; e_zb = 0;
        if (e_hit == 0) return;
        a = 0; b = 0;
        for (int j = 0; j < 4; j++) begin
            p = k - 1 + j;
            if (p >= 1 && p < n) begin
                d = s[p] - s[p-1];
                if (d < 0) d = 0;
                b += wgt[j] * d;
                a += wgt[j] * d * j;
            end
        end
        if (b == 0) begin
            e_zb = 1;
            e_time = k * 16;
        end else begin
            e_time = (k - 1) * 16 + (16 * a) / b;
        end
        for (int c = 0; c < 15; c++) begin
            p = k - 1 + c;
            if (p >= n) begin e_trunc = 1; break; end
            e_chg += s[p];
        end
    endfunction

    task automatic apply_cfg();
        cfg_ped      = LW'(ped);
        cfg_thr      = LW'(thr);
        cfg_min_rise = LW'(min_rise);
        cfg_wgt      = {4'(wgt[3]), 4'(wgt[2]), 4'(wgt[1]), 4'(wgt[0])};
    endtask

    task automatic prog_lut();
        for (int c = 0; c < 256; c++) begin
            cfg_lut_we   = 1'b1;
            cfg_lut_addr = 8'(c);
            cfg_lut_data = LW'(lin_of(c));
            @(negedge clk);
        end
        cfg_lut_we = 1'b0;
    endtask

    task automatic fill_base(int len);
        for (int i = 0; i < 64; i++) win_code[i] = 20 + int'($urandom % 4);
        if (len < 0) return;
    endtask

    task automatic add_pulse(int t0, int amp);
        int prof [15] = '{25, 70, 100, 80, 60, 45, 33, 24, 17, 12, 8, 5, 3, 2, 1};
        for (int i = 0; i < 15; i++) begin
            if (t0 + i < 64) begin
                win_code[t0+i] += amp * prof[i] / 100;
                if (win_code[t0+i] > 255) win_code[t0+i] = 255;
            end
        end
    endtask

    task automatic run_window(string tag, int len, bit junk);
        bit got;
        model(len);
        for (int i = 0; i < len; i++) begin
            smp_valid = 1'b1;
            smp_code  = 8'(win_code[i]);
            smp_last  = (i == len - 1);
            @(negedge clk);
        end
        smp_valid = 1'b0; smp_last = 1'b0;
        got = 0;
        for (int c = 0; c < 300; c++) begin
            if (res_valid) begin got = 1; break; end
            if (junk) begin
                smp_valid = 1'b1;
                smp_code  = 8'($urandom % 256);
                smp_last  = 1'($urandom % 2);
            end
            @(negedge clk);
        end
        smp_valid = 1'b0; smp_last = 1'b0;
        check({tag, " R9 strobe seen"}, int'(got), 1);
        check({tag, " R4 hit"}, int'(res_hit), e_hit);
        check({tag, e_zb ? " R6 time" : " R5/R3 time"}, int'(res_time), e_time);
        check({tag, " R7/R2 charge"}, int'(res_charge), e_chg);
        check({tag, " R8 trunc"}, int'(res_trunc), e_trunc);
        @(negedge clk);
        check({tag, " R9 single pulse"}, int'(res_valid), 0);
    endtask

    initial begin
        void'($urandom(32'd4711));
        ped = 21; thr = 40; min_rise = 10;
        wgt = '{2, 8, 6, 3};
        apply_cfg();
        repeat (3) @(negedge clk);
        check("R1 valid in reset", int'(res_valid), 0);
        check("R1 hit in reset", int'(res_hit), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 time after reset", int'(res_time), 0);
        check("R1 charge after reset", int'(res_charge), 0);
        check("R1 trunc after reset", int'(res_trunc), 0);
        prog_lut();

        // R4: a single-sample spike must be rejected
        fill_base(20); win_code[8] = 200;
        run_window("spike R4", 20, 0);
        check("spike R4 rejected", int'(res_hit), 0);

        // R6: all weights zero
        wgt = '{0, 0, 0, 0}; apply_cfg();
        fill_base(24); add_pulse(5, 180);
        run_window("zero-weight R6", 24, 0);

        // R8: pulse close to the end of the window
        wgt = '{2, 8, 6, 3}; apply_cfg();
        fill_base(20); add_pulse(14, 200);
        run_window("near-end R8", 20, 0);
        check("near-end R8 flag", int'(res_trunc), 1);

        // R10: pulse only after the 32nd sample
        fill_base(40); add_pulse(33, 220);
        run_window("overflow R10 late pulse", 40, 0);
        check("overflow R10 no hit", int'(res_hit), 0);
        fill_base(40); add_pulse(10, 200);
        run_window("overflow R10 early pulse", 40, 0);

        // R11: junk during processing, then a clean window
        fill_base(30); add_pulse(6, 150);
        run_window("busy R11 first", 30, 1);
        fill_base(30); add_pulse(12, 170);
        run_window("busy R11 after junk", 30, 0);

        // R2/R3: identity table, equal rises pick the earliest
        lut_ident = 1; prog_lut();
        ped = 0; thr = 30; min_rise = 5; wgt = '{4, 9, 5, 2}; apply_cfg();
        for (int i = 0; i < 64; i++) win_code[i] = 10;
        win_code[2] = 50; win_code[3] = 90; win_code[4] = 95; win_code[5] = 70;
        run_window("tie R3", 12, 0);
        check("tie R3 earliest bin", int'(res_time) / 16 >= 1 ? 1 : 0, 1);

        lut_ident = 0; prog_lut();
        // random windows
        for (int w = 0; w < 300; w++) begin
            int len;
            ped = 18 + int'($urandom % 6);
            thr = 20 + int'($urandom % 60);
            min_rise = int'($urandom % 40);
            for (int j = 0; j < 4; j++) wgt[j] = int'($urandom % 16);
            apply_cfg();
            len = 1 + int'($urandom % 40);
            fill_base(len);
            if ($urandom % 5 != 0) add_pulse(int'($urandom % len), 30 + int'($urandom % 226));
            run_window("random", len, ($urandom % 4) == 0);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R9 actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule